// File: doc/BRIEF.md
# Load-Use Stall Controller

This block is the hazard detector for a five-stage in-order pipeline. Each cycle it looks at the instruction sitting in decode and at the two instructions ahead of it, in execute and in memory. It decides whether a source operand of the decode instruction comes from an instruction whose result cannot be bypassed in time. If so, it holds the program counter and the fetch/decode register, and it turns the slot entering execute into a bubble. The decision is combinational, so it takes effect on the same clock edge that would otherwise advance the pipeline.

The decision depends on when the consumer needs the value. An ALU operand or a memory address is needed at the start of execute. Store data is needed in the memory stage. A branch that compares registers in decode needs both sources at the start of decode. A loaded value exists only at the end of the memory stage, so the cost is different for each case:

- a loaded register used only as store data costs nothing;
- a loaded register used as an ALU operand or as an address costs one bubble;
- a loaded register used by a decode-stage branch costs two bubbles. The hazard is found again in the second cycle, when the load has moved on to memory.

The outputs are plain control levels with no handshake, because the block only gates the pipeline's own register enables.

Top module: `lduse_stall_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `pc_we` and `ifid_we` are 1 and `idex_bubble` is 0, whatever the other inputs are.
- R2: The three outputs always move together. A stall drives `pc_we`=0, `ifid_we`=0 and `idex_bubble`=1. No stall drives 1, 1, 0.
- R3: `id_kind`=0 (ALU) stalls when either enabled source equals `ex_dst`, and the execute instruction is a load (`ex_is_load`=1, `ex_wr_en`=1, `ex_dst`≠0).
- R4: `id_kind`=1 (load) stalls when its address source `id_src_a` is enabled and matches an execute-stage load. Its `id_src_b` is never considered.
- R5: `id_kind`=2 (store) stalls when its base source `id_src_a` matches an execute-stage load. Its data source `id_src_b` matching an execute-stage load causes no stall.
- R6: For kinds 0, 1 and 2, a load in the memory stage never causes a stall. Neither does an execute-stage producer that is not a load.
- R7: `id_kind`=3 (decode-stage branch) stalls when an enabled source matches a load in execute. It also stalls when an enabled source matches a load in memory (`mem_is_load`=1, `mem_wr_en`=1). As a result, a load followed by a dependent branch gives two consecutive stall cycles. No stall follows once the load leaves memory.
- R8: `id_kind`=3 stalls for one cycle when an enabled source matches a non-load writer in execute (`ex_wr_en`=1, `ex_is_load`=0). A non-load writer in memory never stalls it.
- R9: No stall arises in any of these cases: a destination of 0, a producer with its write enable at 0, a disabled source, or source registers that match no qualifying producer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_src_a | input | REG_W | Decode source A (base address for loads and stores) |
| id_src_a_en | input | 1 | Source A is read |
| id_src_b | input | REG_W | Decode source B (store data for stores) |
| id_src_b_en | input | 1 | Source B is read |
| id_kind | input | 2 | Consumer kind: 0 ALU, 1 load, 2 store, 3 decode-stage branch |
| ex_is_load | input | 1 | Execute instruction reads memory |
| ex_wr_en | input | 1 | Execute instruction writes a register |
| ex_dst | input | REG_W | Execute destination register |
| mem_is_load | input | 1 | Memory-stage instruction reads memory |
| mem_wr_en | input | 1 | Memory-stage instruction writes a register |
| mem_dst | input | REG_W | Memory-stage destination register |
| pc_we | output | 1 | Program counter update enable |
| ifid_we | output | 1 | Fetch/decode register update enable |
| idex_bubble | output | 1 | Clear control fields entering execute |

## Verification
Two checks on one instruction can meet in the same cycle. For a store, the base-address check and the store-data check both run, and they must give opposite answers when only the data register is loaded. For a branch, the execute-stage check and the memory-stage check both run, and each source can be hit by a different producer. Directed cases place a load on the data register and another register on the base. They also place an ALU writer in execute and a load in memory under the two branch sources at once. Dense random traffic over only four register numbers makes such overlaps frequent. Each cycle is judged against a bench function that works out, for each source, the stage in which it is needed.

// File: rtl/lduse_pkg.sv
package lduse_pkg;
  typedef enum logic [1:0] {
    KIND_ALU    = 2'd0,
    KIND_LOAD   = 2'd1,
    KIND_STORE  = 2'd2,
    KIND_BRANCH = 2'd3
  } kind_e;

  // Stage in which a consumer needs a source value.
  typedef enum logic [1:0] {
    NEED_NONE = 2'd0,
    NEED_EX   = 2'd1,
    NEED_MEM  = 2'd2,
    NEED_ID   = 2'd3
  } need_e;

  localparam int NSRC = 2;
endpackage

// File: rtl/lduse_need_map.sv
module lduse_need_map
  import lduse_pkg::*;
(
  input  kind_e kind,
  input  logic  a_en,
  input  logic  b_en,
  output need_e need_a,
  output need_e need_b
);
  need_e raw_a;
  need_e raw_b;

  always_comb begin
    unique case (kind)
      KIND_ALU:    begin raw_a = NEED_EX; raw_b = NEED_EX;   end
      KIND_LOAD:   begin raw_a = NEED_EX; raw_b = NEED_NONE; end
      KIND_STORE:  begin raw_a = NEED_EX; raw_b = NEED_MEM;  end
      KIND_BRANCH: begin raw_a = NEED_ID; raw_b = NEED_ID;   end
      default:     begin raw_a = NEED_NONE; raw_b = NEED_NONE; end
    endcase
  end

  assign need_a = a_en ? raw_a : NEED_NONE;
  assign need_b = b_en ? raw_b : NEED_NONE;
endmodule

// File: rtl/lduse_src_check.sv
module lduse_src_check
  import lduse_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  need_e            need,
  input  logic             ex_is_load,
  input  logic             ex_wr_en,
  input  logic [REG_W-1:0] ex_dst,
  input  logic             mem_is_load,
  input  logic             mem_wr_en,
  input  logic [REG_W-1:0] mem_dst,
  output logic             hit
);
  logic ex_match;
  logic mem_match;

  assign ex_match  = ex_wr_en  && (ex_dst  != '0) && (ex_dst  == src);
  assign mem_match = mem_wr_en && (mem_dst != '0) && (mem_dst == src);

  always_comb begin
    unique case (need)
      NEED_EX:  hit = ex_match && ex_is_load;
      NEED_ID:  hit = ex_match || (mem_match && mem_is_load);
      default:  hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/lduse_stall_ctrl.sv
module lduse_stall_ctrl
  import lduse_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] id_src_a,
  input  logic             id_src_a_en,
  input  logic [REG_W-1:0] id_src_b,
  input  logic             id_src_b_en,
  input  logic [1:0]       id_kind,
  input  logic             ex_is_load,
  input  logic             ex_wr_en,
  input  logic [REG_W-1:0] ex_dst,
  input  logic             mem_is_load,
  input  logic             mem_wr_en,
  input  logic [REG_W-1:0] mem_dst,
  output logic             pc_we,
  output logic             ifid_we,
  output logic             idex_bubble
);
  need_e            need [NSRC];
  logic [REG_W-1:0] srcs [NSRC];
  logic [NSRC-1:0]  hits;
  logic             armed_q;
  logic             stall;

  lduse_need_map u_map (
    .kind   (kind_e'(id_kind)),
    .a_en   (id_src_a_en),
    .b_en   (id_src_b_en),
    .need_a (need[0]),
    .need_b (need[1])
  );

  assign srcs[0] = id_src_a;
  assign srcs[1] = id_src_b;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    lduse_src_check #(.REG_W(REG_W)) u_chk (
      .src         (srcs[i]),
      .need        (need[i]),
      .ex_is_load  (ex_is_load),
      .ex_wr_en    (ex_wr_en),
      .ex_dst      (ex_dst),
      .mem_is_load (mem_is_load),
      .mem_wr_en   (mem_wr_en),
      .mem_dst     (mem_dst),
      .hit         (hits[i])
    );
  end

  // Pipeline holds only bubbles in the first cycle after reset release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  assign stall       = rst_n && armed_q && (|hits);
  assign pc_we       = !stall;
  assign ifid_we     = !stall;
  assign idex_bubble = stall;
endmodule

// File: rtl/lduse_stall_ctrl_chk.sv
module lduse_stall_ctrl_chk #(
  parameter int REG_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [REG_W-1:0] id_src_a,
  input logic             id_src_a_en,
  input logic [1:0]       id_kind,
  input logic             ex_is_load,
  input logic             ex_wr_en,
  input logic [REG_W-1:0] ex_dst,
  input logic             mem_is_load,
  input logic             mem_wr_en,
  input logic [REG_W-1:0] mem_dst,
  input logic             pc_we,
  input logic             ifid_we,
  input logic             idex_bubble
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (pc_we && ifid_we && !idex_bubble)); // R1

  AST_OUTPUTS_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_we == ifid_we) && (idex_bubble == !pc_we)); // R2

  AST_ALU_LOAD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && id_kind == 2'd0 && id_src_a_en && ex_is_load && ex_wr_en
     && ex_dst != '0 && id_src_a == ex_dst) |-> idex_bubble); // R3

  AST_STORE_DATA_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (id_kind == 2'd2 && !id_src_a_en) |-> !idex_bubble); // R5

  AST_NONBRANCH_NO_EX_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
    (id_kind != 2'd3 && !ex_wr_en) |-> !idex_bubble); // R6

  AST_BRANCH_SECOND_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (idex_bubble && id_kind == 2'd3 && id_src_a_en && ex_is_load && ex_wr_en
     && ex_dst != '0 && id_src_a == ex_dst)
    |=> ((id_kind == 2'd3 && id_src_a_en && id_src_a == $past(id_src_a)
          && mem_is_load && mem_wr_en && mem_dst == $past(ex_dst)) -> idex_bubble)); // R7

  AST_NO_WRITER_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!ex_wr_en && !mem_wr_en) |-> !idex_bubble); // R9

  AST_ZERO_DST_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_dst == '0 && mem_dst == '0) |-> !idex_bubble); // R9
endmodule

bind lduse_stall_ctrl lduse_stall_ctrl_chk #(.REG_W(REG_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .id_src_a    (id_src_a),
  .id_src_a_en (id_src_a_en),
  .id_kind     (id_kind),
  .ex_is_load  (ex_is_load),
  .ex_wr_en    (ex_wr_en),
  .ex_dst      (ex_dst),
  .mem_is_load (mem_is_load),
  .mem_wr_en   (mem_wr_en),
  .mem_dst     (mem_dst),
  .pc_we       (pc_we),
  .ifid_we     (ifid_we),
  .idex_bubble (idex_bubble)
);

// File: tb/lduse_stall_ctrl_tb.sv
module lduse_stall_ctrl_tb;
  localparam int REG_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [REG_W-1:0] id_src_a = '0, id_src_b = '0, ex_dst = '0, mem_dst = '0;
  logic id_src_a_en = 1'b0, id_src_b_en = 1'b0;
  logic [1:0] id_kind = 2'd0;
  logic ex_is_load = 1'b0, ex_wr_en = 1'b0, mem_is_load = 1'b0, mem_wr_en = 1'b0;
  logic pc_we, ifid_we, idex_bubble;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lduse_stall_ctrl #(.REG_W(REG_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .id_src_a(id_src_a), .id_src_a_en(id_src_a_en),
    .id_src_b(id_src_b), .id_src_b_en(id_src_b_en),
    .id_kind(id_kind),
    .ex_is_load(ex_is_load), .ex_wr_en(ex_wr_en), .ex_dst(ex_dst),
    .mem_is_load(mem_is_load), .mem_wr_en(mem_wr_en), .mem_dst(mem_dst),
    .pc_we(pc_we), .ifid_we(ifid_we), .idex_bubble(idex_bubble)
  );

  // Stage code: 0 none, 1 execute, 2 memory, 3 decode.
  function automatic int need_of(input logic [1:0] k, input bit is_b);
    case (k)
      2'd0: return 1;
      2'd1: return is_b ? 0 : 1;
      2'd2: return is_b ? 2 : 1;
      default: return 3;
    endcase
  endfunction

  function automatic bit src_stall(input int nd, input logic [REG_W-1:0] s);
    bit exm, memm;
    exm  = ex_wr_en && ex_dst != 0 && ex_dst == s;
    memm = mem_wr_en && mem_dst != 0 && mem_dst == s;
    if (nd == 1) return exm && ex_is_load;
    if (nd == 3) return exm || (memm && mem_is_load);
    return 1'b0;
  endfunction

  function automatic bit exp_stall();
    bit st;
    st = 1'b0;
    if (id_src_a_en) st |= src_stall(need_of(id_kind, 1'b0), id_src_a);
    if (id_src_b_en) st |= src_stall(need_of(id_kind, 1'b1), id_src_b);
    return st;
  endfunction

  task automatic check(input string tag, input bit exp_st);
    logic [2:0] act, exp;
    act = {pc_we, ifid_we, idex_bubble};
    exp = exp_st ? 3'b001 : 3'b110;
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {pc_we,ifid_we,bubble} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] k,
                       input logic [REG_W-1:0] a, input logic ae,
                       input logic [REG_W-1:0] b, input logic be,
                       input logic el, input logic ew, input logic [REG_W-1:0] ed,
                       input logic ml, input logic mw, input logic [REG_W-1:0] md);
    @(negedge clk);
    id_kind = k; id_src_a = a; id_src_a_en = ae; id_src_b = b; id_src_b_en = be;
    ex_is_load = el; ex_wr_en = ew; ex_dst = ed;
    mem_is_load = ml; mem_wr_en = mw; mem_dst = md;
    #1;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: hazard present during reset and first cycle after release
    drive(2'd0, 5'd3, 1, 5'd0, 0, 1, 1, 5'd3, 0, 0, 5'd0);
    check("R1 in reset", 1'b0);
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; #1;
    check("R1 first cycle after release", 1'b0);
    @(posedge clk); #1;
    check("R1/R3 armed hazard", 1'b1);

    // R3 ALU consumer via source B
    drive(2'd0, 5'd1, 1, 5'd7, 1, 1, 1, 5'd7, 0, 0, 5'd0);
    check("R3 alu src b load", 1'b1);
    // R4 load address from load; source B ignored
    drive(2'd1, 5'd4, 1, 5'd9, 0, 1, 1, 5'd4, 0, 0, 5'd0);
    check("R4 load address", 1'b1);
    drive(2'd1, 5'd2, 1, 5'd9, 1, 1, 1, 5'd9, 0, 0, 5'd0);
    check("R4 load src b ignored", 1'b0);
    // R5 store data vs base, both in one cycle
    drive(2'd2, 5'd1, 1, 5'd6, 1, 1, 1, 5'd6, 0, 0, 5'd0);
    check("R5 store data free", 1'b0);
    drive(2'd2, 5'd6, 1, 5'd6, 1, 1, 1, 5'd6, 0, 0, 5'd0);
    check("R5 store base stalls", 1'b1);
    // R6 filler: load in memory, ALU consumer
    drive(2'd0, 5'd5, 1, 5'd0, 0, 0, 1, 5'd8, 1, 1, 5'd5);
    check("R6 load in mem no stall", 1'b0);
    drive(2'd0, 5'd5, 1, 5'd0, 0, 0, 1, 5'd5, 0, 0, 5'd0);
    check("R6 alu producer forwarded", 1'b0);
    // R7 load then branch: two bubbles, then release
    drive(2'd3, 5'd2, 1, 5'd3, 1, 1, 1, 5'd2, 0, 0, 5'd0);
    check("R7 branch cycle A", 1'b1);
    drive(2'd3, 5'd2, 1, 5'd3, 1, 0, 0, 5'd0, 1, 1, 5'd2);
    check("R7 branch cycle B", 1'b1);
    drive(2'd3, 5'd2, 1, 5'd3, 1, 0, 0, 5'd0, 0, 0, 5'd0);
    check("R7 branch cycle C", 1'b0);
    // R8 branch on ALU writer
    drive(2'd3, 5'd4, 1, 5'd0, 0, 0, 1, 5'd4, 0, 0, 5'd0);
    check("R8 branch ex alu", 1'b1);
    drive(2'd3, 5'd4, 1, 5'd0, 0, 0, 0, 5'd0, 0, 1, 5'd4);
    check("R8 branch mem alu", 1'b0);
    drive(2'd3, 5'd4, 1, 5'd6, 1, 0, 1, 5'd4, 1, 1, 5'd6);
    check("R7/R8 branch two producers", 1'b1);
    // R9 corner cases
    drive(2'd0, 5'd0, 1, 5'd0, 1, 1, 1, 5'd0, 1, 1, 5'd0);
    check("R9 zero dst", 1'b0);
    drive(2'd0, 5'd3, 1, 5'd3, 1, 1, 0, 5'd3, 0, 0, 5'd0);
    check("R9 no write enable", 1'b0);
    drive(2'd3, 5'd3, 0, 5'd3, 0, 1, 1, 5'd3, 1, 1, 5'd3);
    check("R9 sources disabled", 1'b0);
    drive(2'd0, 5'd1, 1, 5'd2, 1, 1, 1, 5'd3, 0, 0, 5'd0);
    check("R9 no match", 1'b0);

    // Random traffic, fixed seed, small register range
    void'($urandom(32'd1234));
    for (int i = 0; i < 400; i++) begin
      drive(2'($urandom_range(0, 3)),
            5'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
            5'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
            1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 5'($urandom_range(0, 3)),
            1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 5'($urandom_range(0, 3)));
      check("R2 random", exp_stall());
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule